// File: doc/BRIEF.md
# Pending-table best-interrupt scanner

This block finds the most urgent pending message-signalled interrupt whose state lives in memory instead of in on-chip flops. Two tables sit in system memory: a pending bitmap (one bit per interrupt ID) and a configuration table (one byte per interrupt ID, holding an enable bit and a priority field). On a scan request the block walks the pending bitmap one byte per read. For every set bit it fetches that interrupt's configuration byte. It keeps the winning ID and its effective priority, then reports them with a one-cycle completion pulse.

Besides full scans, the block takes single-interrupt updates from the logic that maintains the pending table. When one interrupt becomes pending, only that interrupt's configuration byte is fetched and compared with the current winner. When the current winner stops being pending, a full rescan runs. Configuration inputs (enable, bases, ID-bits field, security-off flag) must stay stable while `busy` is high.

Top module: `pend_best_scan`

## Requirements
- R1: After reset `busy`, `done`, `mem_req` and `best_valid` are 0 and `best_prio` is 8'hFF.
- R2: A scan request while `irq_en` is 0, or while either base address is zero, makes no memory read. It gives one `done` pulse and leaves `best_valid`, `best_id` and `best_prio` unchanged.
- R3: The table holds 2^(e+1) IDs, where e = min(`id_bits`, MAX_IDBITS). A scan reads pending bytes at `pend_base` + k for k = 1024 up to 2^(e+1)/8 - 1 in rising order. Bit b of byte k is ID 8k+b, and set bits in a byte are taken lowest first. When e < 13 the range is empty and the scan ends with nothing found.
- R4: For a pending ID the configuration byte is read at `cfg_base` + (ID - 8192). If its bit 0 (enable) is 0, the ID is skipped.
- R5: The priority field is the configuration byte ANDed with 8'hFC. With `sec_off` = 1 the effective priority is the field itself; with `sec_off` = 0 it is (field >> 1) | 8'h80.
- R6: A scan starts with `best_prio` = 8'hFF and `best_valid` = 0. A candidate replaces the winner when its priority is numerically lower, or when the priorities are equal and its ID is lower than or equal to the winner's ID. `best_valid` goes to 1 on the first replacement.
- R7: An update with `upd_set` = 1 reads only that ID's configuration byte. It applies the R6 rule without resetting the winner, then pulses `done`.
- R8: An update with `upd_set` = 0 for the current winning ID (with `best_valid` = 1) runs a full rescan. For any other ID it has no effect and makes no memory read.
- R9: An update is ignored when its ID is below 8192, is at or above 2^(e+1), or when `irq_en` is 0 or a base is zero.
- R10: `mem_req` stays high with `mem_addr` stable until `mem_ack` is sampled high. `mem_rdata` is taken in that cycle, and each request transfers exactly one byte.
- R11: `busy` is high from the cycle after an accepted request until the end of the operation. `scan_start` and `upd_valid` are ignored while `busy` is high, and `done` is a single-cycle pulse with the results already valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Enables scanning and updates |
| sec_off | input | 1 | 1 selects the raw priority view, 0 the folded view |
| id_bits | input | IDB_W | Programmed ID-width field (clamped to MAX_IDBITS) |
| pend_base | input | ADDR_W | Byte address of the pending bitmap |
| cfg_base | input | ADDR_W | Byte address of the configuration table for ID 8192 |
| scan_start | input | 1 | Request a full scan |
| upd_valid | input | 1 | Single-interrupt update strobe |
| upd_set | input | 1 | 1 = interrupt became pending, 0 = it was cleared |
| upd_id | input | ID_W | Interrupt ID of the update |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| best_valid | output | 1 | A winning interrupt is held |
| best_id | output | ID_W | Winning interrupt ID |
| best_prio | output | 8 | Winning effective priority |

## Verification
The scan is tried with pairs of pending IDs in different bytes and in the same byte, so that walk order and bit order both matter. It is run in both priority views and with disabled entries, reserved low configuration bits, equal priorities and the first and last legal IDs. Separate cases clamp the ID field above its maximum with a pending bit planted just past the table, and set it below the first ID. In both, counting memory reads shows whether the walked range is exact. The update cases tell apart a lower-ID tie (replaces) from a higher-ID tie (keeps), a clear of a non-winner (silent) from a clear of the winner (rescan), and out-of-range or disabled updates that would otherwise win.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  // First interrupt ID held in the tables
  localparam int unsigned FIRST_ID = 8192;
  localparam logic [7:0] PRIO_NONE = 8'hFF;
  localparam logic [7:0] PRIO_FIELD = 8'hFC;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_PWAIT,
    ST_PICK,
    ST_CWAIT,
    ST_DONE
  } scan_st_e;

  // Effective priority of a configuration byte in the selected view
  function automatic logic [7:0] eff_prio(input logic [7:0] cfg, input logic sec_off);
    logic [7:0] fld;
    fld = cfg & PRIO_FIELD;
    return sec_off ? fld : ({1'b0, fld[7:1]} | 8'h80);
  endfunction
endpackage

// File: rtl/pbs_rdport.sv
module pbs_rdport #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              rd_done,
  output logic [7:0]        rd_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      rd_done  <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rd_done <= 1'b0;
      if (rd_go) begin
        mem_req  <= 1'b1;
        mem_addr <= rd_addr;
      end else if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        rd_done <= 1'b1;
        rd_byte <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/pbs_lowbit.sv
module pbs_lowbit #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  first
);
  for (genvar i = 0; i < W; i++) begin : g_first
    if (i == 0) begin : g_lsb
      assign first[i] = bits[i];
    end else begin : g_up
      assign first[i] = bits[i] & ~(|bits[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pbs_cmp.sv
module pbs_cmp
  import pbs_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic [7:0]      cfg,
  input  logic            sec_off,
  input  logic [ID_W-1:0] cand_id,
  input  logic [ID_W-1:0] best_id,
  input  logic [7:0]      best_prio,
  output logic [7:0]      cand_prio,
  output logic            take
);
  assign cand_prio = eff_prio(cfg, sec_off);
  // Enabled, and strictly more urgent or equal with an ID not above the winner
  assign take = cfg[0] &&
                ((cand_prio < best_prio) ||
                 ((cand_prio == best_prio) && (cand_id <= best_id)));
endmodule

// File: rtl/pend_best_scan.sv
module pend_best_scan
  import pbs_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 16,
  parameter int MAX_IDBITS = 13,
  parameter int IDB_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_en,
  input  logic              sec_off,
  input  logic [IDB_W-1:0]  id_bits,
  input  logic [ADDR_W-1:0] pend_base,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              scan_start,
  input  logic              upd_valid,
  input  logic              upd_set,
  input  logic [ID_W-1:0]   upd_id,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              best_valid,
  output logic [ID_W-1:0]   best_id,
  output logic [7:0]        best_prio
);
  localparam int BYTE_W = ID_W - 2;
  localparam logic [BYTE_W-1:0] START_BYTE = BYTE_W'(FIRST_ID / 8);
  localparam logic [ID_W-1:0]   FIRST_W    = ID_W'(FIRST_ID);

  scan_st_e          st;
  logic [BYTE_W-1:0] byte_idx;
  logic [7:0]        pend_q;
  logic [ID_W-1:0]   cand_q;
  logic              single_q;
  logic [ID_W-1:0]   best_id_q;
  logic [7:0]        best_prio_q;
  logic              best_valid_q;

  logic [IDB_W-1:0]  eff_bits;
  logic [ID_W:0]     tbl_ids;
  logic [BYTE_W-1:0] end_byte;
  logic              active, upd_ok;
  logic              go_scan, go_single, go_nop;
  logic              rd_go, rd_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_byte;
  logic [2:0]        bit_idx;
  logic [7:0]        bit_first;
  logic [ID_W-1:0]   pick_id;
  logic [7:0]        cand_prio;
  logic              take;

  // Table geometry from the clamped ID field
  assign eff_bits = (id_bits > IDB_W'(MAX_IDBITS)) ? IDB_W'(MAX_IDBITS) : id_bits;
  assign tbl_ids  = (ID_W+1)'(1) << (eff_bits + IDB_W'(1));
  assign end_byte = BYTE_W'(tbl_ids >> 3);
  assign active   = irq_en && (|pend_base) && (|cfg_base);
  assign upd_ok   = (upd_id >= FIRST_W) && ({1'b0, upd_id} < tbl_ids);
  assign pick_id  = ID_W'({byte_idx, bit_idx});

  // Request decode in idle: a scan request wins over an update
  always_comb begin
    go_scan   = 1'b0;
    go_single = 1'b0;
    go_nop    = 1'b0;
    if (st == ST_IDLE) begin
      if (scan_start) begin
        go_scan = active;
        go_nop  = !active;
      end else if (upd_valid && active && upd_ok) begin
        go_single = upd_set;
        go_scan   = !upd_set && best_valid_q && (upd_id == best_id_q);
      end
    end
  end

  // Read issue: pending bytes in order, then config bytes of set bits
  always_comb begin
    rd_go   = 1'b0;
    rd_addr = '0;
    unique case (st)
      ST_IDLE: if (go_single) begin
        rd_go   = 1'b1;
        rd_addr = cfg_base + ADDR_W'(upd_id - FIRST_W);
      end
      ST_NEXT: if (byte_idx < end_byte) begin
        rd_go   = 1'b1;
        rd_addr = pend_base + ADDR_W'(byte_idx);
      end
      ST_PICK: if (|pend_q) begin
        rd_go   = 1'b1;
        rd_addr = cfg_base + ADDR_W'(pick_id - FIRST_W);
      end
      default: ;
    endcase
  end

  pbs_rdport #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .rd_go(rd_go), .rd_addr(rd_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rd_done(rd_done), .rd_byte(rd_byte)
  );

  pbs_lowbit #(.W(8)) u_low (
    .bits(pend_q), .idx(bit_idx), .first(bit_first)
  );

  pbs_cmp #(.ID_W(ID_W)) u_cmp (
    .cfg(rd_byte), .sec_off(sec_off), .cand_id(cand_q),
    .best_id(best_id_q), .best_prio(best_prio_q),
    .cand_prio(cand_prio), .take(take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      byte_idx     <= '0;
      pend_q       <= '0;
      cand_q       <= '0;
      single_q     <= 1'b0;
      best_id_q    <= '0;
      best_prio_q  <= PRIO_NONE;
      best_valid_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (go_scan) begin
            best_prio_q  <= PRIO_NONE;
            best_valid_q <= 1'b0;
            byte_idx     <= START_BYTE;
            single_q     <= 1'b0;
            st           <= ST_NEXT;
          end else if (go_single) begin
            cand_q   <= upd_id;
            single_q <= 1'b1;
            st       <= ST_CWAIT;
          end else if (go_nop) begin
            st <= ST_DONE;
          end
        end
        ST_NEXT:  st <= (byte_idx < end_byte) ? ST_PWAIT : ST_DONE;
        ST_PWAIT: if (rd_done) begin
          pend_q <= rd_byte;
          st     <= ST_PICK;
        end
        ST_PICK: begin
          if (|pend_q) begin
            cand_q <= pick_id;
            pend_q <= pend_q & ~bit_first;
            st     <= ST_CWAIT;
          end else begin
            byte_idx <= byte_idx + BYTE_W'(1);
            st       <= ST_NEXT;
          end
        end
        ST_CWAIT: if (rd_done) begin
          if (take) begin
            best_id_q    <= cand_q;
            best_prio_q  <= cand_prio;
            best_valid_q <= 1'b1;
          end
          st <= single_q ? ST_DONE : ST_PICK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_DONE);
  assign best_valid = best_valid_q;
  assign best_id    = best_id_q;
  assign best_prio  = best_prio_q;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_start,
  input logic              upd_valid,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic              best_valid,
  input logic [ID_W-1:0]   best_id,
  input logic [7:0]        best_prio
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R11
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && scan_start) |=> busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  valid_prio_chk: assert property (@(posedge clk) disable iff (rst)
    best_valid |-> (best_prio != 8'hFF));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !scan_start && !upd_valid) |=>
      ($stable(best_prio) && $stable(best_valid) && $stable(best_id)));
endmodule

bind pend_best_scan pbs_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .scan_start(scan_start), .upd_valid(upd_valid),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .busy(busy), .done(done), .best_valid(best_valid),
  .best_id(best_id), .best_prio(best_prio)
);

// File: tb/pend_best_scan_tb.sv
module pend_best_scan_tb;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 16;
  localparam logic [31:0] PB = 32'h1000_0000;
  localparam logic [31:0] CB = 32'h2000_0000;

  typedef struct packed {
    logic        sd;
    logic [15:0] ida;
    logic [7:0]  cfa;
    logic [15:0] idb;
    logic [7:0]  cfb;
    logic        ev;
    logic [15:0] eid;
    logic [7:0]  ep;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'd8200,  8'h41, 16'd9000,  8'h81, 1'b1, 16'd8200,  8'h40},
    '{1'b1, 16'd8200,  8'h81, 16'd9000,  8'h41, 1'b1, 16'd9000,  8'h40},
    '{1'b0, 16'd8300,  8'h41, 16'd8301,  8'h21, 1'b1, 16'd8301,  8'h90},
    '{1'b1, 16'd8400,  8'h61, 16'd8192,  8'h61, 1'b1, 16'd8192,  8'h60},
    '{1'b1, 16'd8500,  8'h40, 16'd16383, 8'hFD, 1'b1, 16'd16383, 8'hFC},
    '{1'b1, 16'd8500,  8'h40, 16'd8600,  8'h00, 1'b0, 16'd0,     8'hFF},
    '{1'b1, 16'd8200,  8'h43, 16'd8201,  8'h45, 1'b1, 16'd8200,  8'h40}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              irq_en = 1'b0;
  logic              sec_off = 1'b1;
  logic [4:0]        id_bits = 5'd13;
  logic [ADDR_W-1:0] pend_base = PB;
  logic [ADDR_W-1:0] cfg_base = CB;
  logic              scan_start = 1'b0;
  logic              upd_valid = 1'b0;
  logic              upd_set = 1'b0;
  logic [ID_W-1:0]   upd_id = '0;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ack = 1'b0;
  logic [7:0]        mem_rdata = 8'h00;
  logic              busy, done, best_valid;
  logic [ID_W-1:0]   best_id;
  logic [7:0]        best_prio;

  int nchk = 0;
  int nerr = 0;
  int rd_count = 0;
  int r0;
  logic [7:0] mem [logic [31:0]];

  always #5 clk = ~clk;

  pend_best_scan u_dut (
    .clk(clk), .rst(rst), .irq_en(irq_en), .sec_off(sec_off), .id_bits(id_bits),
    .pend_base(pend_base), .cfg_base(cfg_base), .scan_start(scan_start),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_id(upd_id),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .best_valid(best_valid), .best_id(best_id),
    .best_prio(best_prio)
  );

  function automatic logic [7:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic set_pend(input int id, input logic on);
    logic [31:0] a;
    logic [7:0] v;
    a = PB + 32'(id / 8);
    v = mrd(a);
    v[id % 8] = on;
    mem[a] = v;
  endtask

  task automatic set_cfg(input int id, input logic [7:0] v);
    mem[CB + 32'(id - 8192)] = v;
  endtask

  // Memory responder with latency cycling through 0, 1, 2 wait cycles
  initial begin
    int lat_cnt = 0;
    int lat_tgt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (lat_cnt >= lat_tgt) begin
          mem_ack   = 1'b1;
          mem_rdata = mrd(mem_addr);
          rd_count++;
          lat_cnt = 0;
          lat_tgt = (lat_tgt + 1) % 3;
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic wait_done(input string what);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk({what, " done seen"}, 32'(done), 32'd1);
  endtask

  task automatic run_scan(input string what);
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    wait_done(what);
    @(negedge clk);
  endtask

  task automatic send_upd(input logic set, input int id);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_set   = set;
    upd_id    = ID_W'(id);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic check_best(input string what, input int id, input logic [7:0] p);
    chk({what, " best_valid"}, 32'(best_valid), 32'd1);
    chk({what, " best_id"}, 32'(best_id), 32'(id));
    chk({what, " best_prio"}, 32'(best_prio), 32'(p));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 best_valid", 32'(best_valid), 0);
    chk("R1 best_prio", 32'(best_prio), 32'hFF);
    irq_en = 1'b1;

    // Vector table: two pending IDs per entry (R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      mem.delete();
      sec_off = VEC[i].sd;
      set_pend(int'(VEC[i].ida), 1'b1);
      set_cfg(int'(VEC[i].ida), VEC[i].cfa);
      set_pend(int'(VEC[i].idb), 1'b1);
      set_cfg(int'(VEC[i].idb), VEC[i].cfb);
      run_scan("R3 vector");
      chk($sformatf("R6 vec%0d valid", i), 32'(best_valid), 32'(VEC[i].ev));
      chk($sformatf("R5 vec%0d prio", i), 32'(best_prio), 32'(VEC[i].ep));
      if (VEC[i].ev) chk($sformatf("R4 vec%0d id", i), 32'(best_id), 32'(VEC[i].eid));
    end

    // R2: disabled or zero base leaves result and makes no reads
    irq_en = 1'b0;
    r0 = rd_count;
    run_scan("R2 disabled");
    check_best("R2 disabled", 8200, 8'h40);
    chk("R2 disabled reads", 32'(rd_count - r0), 0);
    irq_en = 1'b1;
    pend_base = '0;
    run_scan("R2 zero base");
    check_best("R2 zero base", 8200, 8'h40);
    chk("R2 zero base reads", 32'(rd_count - r0), 0);
    pend_base = PB;

    // R3: field above maximum clamps; bit just past the table is never read
    mem.delete();
    sec_off = 1'b1;
    id_bits = 5'd31;
    set_pend(16383, 1'b1); set_cfg(16383, 8'h81);
    set_pend(16384, 1'b1); set_cfg(16384, 8'h01);
    r0 = rd_count;
    run_scan("R3 clamp");
    check_best("R3 clamp", 16383, 8'h80);
    chk("R10 one byte per request count", 32'(rd_count - r0), 32'd1025);

    // R3: field below first ID gives an empty walk
    id_bits = 5'd12;
    r0 = rd_count;
    run_scan("R3 empty");
    chk("R3 empty valid", 32'(best_valid), 0);
    chk("R3 empty prio", 32'(best_prio), 32'hFF);
    chk("R3 empty reads", 32'(rd_count - r0), 0);
    id_bits = 5'd13;

    // R7: single set updates
    mem.delete();
    set_pend(8200, 1'b1); set_cfg(8200, 8'h41);
    run_scan("R7 base");
    check_best("R7 base", 8200, 8'h40);
    set_pend(9000, 1'b1); set_cfg(9000, 8'h21);
    r0 = rd_count;
    send_upd(1'b1, 9000);
    wait_done("R7 set");
    check_best("R7 set better", 9000, 8'h20);
    chk("R7 single read", 32'(rd_count - r0), 1);
    set_pend(9100, 1'b1); set_cfg(9100, 8'h21);
    send_upd(1'b1, 9100);
    wait_done("R6 tie higher");
    check_best("R6 tie higher id keeps", 9000, 8'h20);
    set_pend(8999, 1'b1); set_cfg(8999, 8'h21);
    send_upd(1'b1, 8999);
    wait_done("R6 tie lower");
    check_best("R6 tie lower id replaces", 8999, 8'h20);

    // R9: ignored updates
    set_cfg(9500, 8'h01);
    r0 = rd_count;
    send_upd(1'b1, 8191);
    repeat (20) @(negedge clk);
    send_upd(1'b1, 16384);
    repeat (20) @(negedge clk);
    irq_en = 1'b0;
    send_upd(1'b1, 9500);
    repeat (20) @(negedge clk);
    irq_en = 1'b1;
    chk("R9 ignored busy", 32'(busy), 0);
    check_best("R9 ignored", 8999, 8'h20);
    chk("R9 ignored reads", 32'(rd_count - r0), 0);

    // R8: clear of a non-winner, then of the winner
    r0 = rd_count;
    send_upd(1'b0, 9000);
    repeat (20) @(negedge clk);
    check_best("R8 clear other", 8999, 8'h20);
    chk("R8 clear other reads", 32'(rd_count - r0), 0);
    set_pend(8999, 1'b0);
    send_upd(1'b0, 8999);
    wait_done("R8 rescan");
    @(negedge clk);
    check_best("R8 rescan", 9000, 8'h20);

    // R11: busy, requests ignored while busy, single done pulse
    set_pend(9500, 1'b0);
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
    chk("R11 busy after start", 32'(busy), 1);
    upd_valid = 1'b1; upd_set = 1'b1; upd_id = ID_W'(9500);
    @(negedge clk);
    upd_valid = 1'b0;
    wait_done("R11 scan");
    check_best("R11 update ignored while busy", 9000, 8'h20);
    @(negedge clk);
    chk("R11 done single cycle", 32'(done), 0);
    chk("R11 idle after", 32'(busy), 0);

    finish_up();
  end
endmodule